// File: doc/BRIEF.md
# On-Screen Text Window Position Generator

This block places a rectangular text area on a television raster. It follows the incoming horizontal and vertical sync pulses. It tells the character generator on which lines the text area is open, and when each open line's text should begin. Two small position codes move the area for set-up: a 2-bit code shifts the horizontal start and a 3-bit code shifts the first text line. The first line also depends on whether the set runs a 625-line or a 525-line standard.

Line counting restarts at every vertical sync, so the window follows either line standard without being told the field length. The window stays open for a fixed number of lines, or it closes early when the next vertical sync ends the field. A field-adjust input moves the first line down by one line. It is used when the deflection stage shifts one field by half a line. All position inputs are captured at the vertical sync edge, so a change takes effect at the start of the next field.

Top module: `osd_window_pos`

## Requirements
- R1: After the clock edge that first samples `hsync` high, `hstart` rises D clocks later. D = (172 − 10·X) · TICKS_PER_TENTH_US, where X is the captured `xpos` as an unsigned number. This gives 17.2, 16.2, 15.2 or 14.2 µs for X = 0, 1, 2, 3.
- R2: With `std_625` = 1, the first window line for `ypos` = 0..7 is 42, 44, 46, 48, 34, 36, 38, 40.
- R3: With `std_625` = 0, the first window line for `ypos` = 0..7 is 28, 30, 32, 34, 20, 22, 24, 26.
- R4: `vwin` stays high for exactly WIN_LINES consecutive lines, starting at the first window line.
- R5: A rising edge of `vsync` restarts line counting. An open window closes at that edge, even if fewer than WIN_LINES lines have passed.
- R6: The first rising `hsync` after a `vsync` rise starts line 1. `line_idx` is 0 on the first window line and rises by one on each later line. It is 0 whenever `vwin` is low.
- R7: When `fld_adj` = 1 at the vertical sync edge, the first window line of that field is one line later than the table value.
- R8: `xpos`, `ypos`, `std_625` and `fld_adj` are captured only at the `vsync` rising edge. Changes during a field do not affect that field.
- R9: `hstart` is a single-cycle pulse and occurs only on lines where `vwin` is high.
- R10: While `rst_n` is low, `vwin`, `hstart` and `line_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync, rising edge active, synchronous to `clk` |
| vsync | input | 1 | Vertical sync, rising edge active, synchronous to `clk` |
| std_625 | input | 1 | 1 = 625-line standard, 0 = 525-line standard |
| xpos | input | 2 | Horizontal position code |
| ypos | input | 3 | Vertical position code |
| fld_adj | input | 1 | Field-adjust flag; 1 delays the first line by one |
| vwin | output | 1 | Vertical window open on the current line |
| hstart | output | 1 | One-cycle strobe marking the text start on an open line |
| line_idx | output | IDX_W | Line index inside the window, 0 on the first line |

## Verification
The bench builds the block with TICKS_PER_TENTH_US = 1 and WIN_LINES = 20. With these values the four horizontal delays are 172, 162, 152 and 142 clocks, and each fits inside a 180-clock test line. The shortened window runs its full length and closes well inside a 75-line field. A field of 40 lines is also short enough that the window is cut off by the next vertical sync. Several codes from both standard tables are run, along with the field-adjust offset and a change of codes in the middle of a field.

// File: rtl/osd_win_pkg.sv
// Package: shared constants and the first-line lookup for the text window.
// Assumes line numbers fit in 9 bits, which covers both line standards.
package osd_win_pkg;

    localparam int HDLY_BASE_TENTHS = 172;  // delay for code 0, in 0.1 us
    localparam int HDLY_STEP_TENTHS = 10;   // 1 us per code step
    localparam int FL_W             = 9;

    // Returns the first window line for a standard, a vertical code and the field-adjust flag.
    function automatic logic [FL_W-1:0] first_line(input logic       std625,
                                                   input logic [2:0] ycode,
                                                   input logic       adj);
        logic [FL_W-1:0] base;
        base = std625 ? 9'd42 : 9'd28;
        if (ycode[2]) begin
            base = base - 9'd8;
        end
        base = base + {6'd0, ycode[1:0], 1'b0};
        base = base + {8'd0, adj};
        return base;
    endfunction

endpackage

// File: rtl/osd_edge_rise.sv
// Module: rising-edge detector for one sync input.
// Assumes the input is already synchronous to clk. The pulse is high in the
// cycle before the edge that first samples the input high.
module osd_edge_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    logic sig_q;

    // Keep the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig;
        end
    end

    // A high input with a low previous sample marks a rising edge.
    always_comb begin
        rise = sig & ~sig_q;
    end

endmodule

// File: rtl/osd_vline.sv
// Module: counts lines from vertical sync and opens the vertical window.
// Assumes LINE_W >= 10, so every first-line value plus WIN_LINES fits.
// The counter saturates and does not wrap in very long fields.
module osd_vline
    import osd_win_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int WIN_LINES = 250,
    parameter int IDX_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_edge,
    input  logic             vs_edge,
    input  logic             std_625,
    input  logic [2:0]       ypos,
    input  logic             fld_adj,
    output logic             vwin,
    output logic [IDX_W-1:0] line_idx
);

    localparam int CW = LINE_W + 1;
    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    logic [LINE_W-1:0] line_cnt;
    logic [FL_W-1:0]   fl_q;
    logic [CW-1:0]     cnt_x;
    logic [CW-1:0]     fl_x;
    logic [CW-1:0]     end_x;
    logic [CW-1:0]     offs;

    // Restart at vertical sync and capture the position, otherwise count lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            fl_q     <= first_line(1'b1, 3'd0, 1'b0);
        end else if (vs_edge) begin
            line_cnt <= '0;
            fl_q     <= first_line(std_625, ypos, fld_adj);
        end else if (hs_edge && (line_cnt != CNT_MAX)) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    // The window is open from the first line for WIN_LINES lines.
    always_comb begin
        cnt_x    = {1'b0, line_cnt};
        fl_x     = CW'(fl_q);
        end_x    = fl_x + CW'(WIN_LINES);
        vwin     = (cnt_x >= fl_x) && (cnt_x < end_x);
        offs     = cnt_x - fl_x;
        line_idx = vwin ? offs[IDX_W-1:0] : '0;
    end

endmodule

// File: rtl/osd_hdelay.sv
// Module: times the horizontal text start after each horizontal sync.
// Assumes the line period is longer than the largest delay. A new sync
// restarts the timer, and a vertical sync cancels it and captures the code.
module osd_hdelay
    import osd_win_pkg::*;
#(
    parameter int TICKS_PER_TENTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_go,
    input  logic       abort,
    input  logic [1:0] xpos,
    input  logic       win_on,
    output logic       hstart
);

    localparam int MAX_DLY = HDLY_BASE_TENTHS * TICKS_PER_TENTH;
    localparam int HCW     = $clog2(MAX_DLY + 1);

    logic [1:0]     x_q;
    logic [HCW-1:0] hcnt;
    logic           hrun;
    logic [HCW-1:0] dly;

    // Delay in clocks for the captured code.
    always_comb begin
        dly = HCW'((HDLY_BASE_TENTHS - HDLY_STEP_TENTHS * int'(x_q)) * TICKS_PER_TENTH);
    end

    // Load on sync, count down, and strobe at zero if the line is in the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            hcnt   <= '0;
            hrun   <= 1'b0;
            hstart <= 1'b0;
        end else begin
            hstart <= 1'b0;
            if (abort) begin
                x_q  <= xpos;
                hrun <= 1'b0;
            end else if (line_go) begin
                hcnt <= dly - 1'b1;
                hrun <= 1'b1;
            end else if (hrun) begin
                if (hcnt == '0) begin
                    hrun   <= 1'b0;
                    hstart <= win_on;
                end else begin
                    hcnt <= hcnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/osd_window_pos.sv
// Module: top of the text window position generator.
// Assumes hsync and vsync are synchronous to clk and active on their rising edges.
module osd_window_pos #(
    parameter int TICKS_PER_TENTH_US = 2,
    parameter int LINE_W             = 10,
    parameter int WIN_LINES          = 250,
    parameter int IDX_W              = $clog2(WIN_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             std_625,
    input  logic [1:0]       xpos,
    input  logic [2:0]       ypos,
    input  logic             fld_adj,
    output logic             vwin,
    output logic             hstart,
    output logic [IDX_W-1:0] line_idx
);

    logic hs_edge;
    logic vs_edge;

    // Horizontal sync edge.
    osd_edge_rise u_hs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (hsync),
        .rise  (hs_edge)
    );

    // Vertical sync edge.
    osd_edge_rise u_vs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (vsync),
        .rise  (vs_edge)
    );

    // Line counter and vertical window.
    osd_vline #(
        .LINE_W    (LINE_W),
        .WIN_LINES (WIN_LINES),
        .IDX_W     (IDX_W)
    ) u_vline (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_edge  (hs_edge),
        .vs_edge  (vs_edge),
        .std_625  (std_625),
        .ypos     (ypos),
        .fld_adj  (fld_adj),
        .vwin     (vwin),
        .line_idx (line_idx)
    );

    // Horizontal start timer.
    osd_hdelay #(
        .TICKS_PER_TENTH (TICKS_PER_TENTH_US)
    ) u_hdelay (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_go (hs_edge),
        .abort   (vs_edge),
        .xpos    (xpos),
        .win_on  (vwin),
        .hstart  (hstart)
    );

endmodule

// File: rtl/osd_window_chk.sv
// Checker: temporal properties on the window outputs. It is bound to the top module.
module osd_window_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync,
    input logic             vsync,
    input logic             vwin,
    input logic             hstart,
    input logic [IDX_W-1:0] line_idx
);

    // R9: the strobe lasts one cycle.
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hstart |=> !hstart);

    // R9: the strobe only occurs on open lines.
    assert_strobe_in_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hstart |-> vwin);

    // R6: the index is zero outside the window.
    assert_idx_zero_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vwin |-> (line_idx == '0));

    // R6: inside the window, the index holds or steps by one.
    assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vwin && $past(vwin)) |->
            ((line_idx == $past(line_idx)) || (line_idx == IDX_W'($past(line_idx) + 1'b1))));

    // R4, R5: the window closes only at a sync edge.
    assert_close_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vwin) |-> ($past(hsync) || $past(vsync)));

    // R10: outputs are quiet while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!hstart);
        end
    end

endmodule

bind osd_window_pos osd_window_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync    (hsync),
    .vsync    (vsync),
    .vwin     (vwin),
    .hstart   (hstart),
    .line_idx (line_idx)
);

// File: tb/sim_osd_window_pos.sv
// Directed bench for the text window position generator.
module sim_osd_window_pos;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_CLKS  = 180;
    localparam int TPT        = 1;
    localparam int WIN        = 20;
    localparam int IW         = $clog2(WIN);
    localparam int WATCHDOG   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsync = 1'b0;
    logic          vsync = 1'b0;
    logic          std_625 = 1'b1;
    logic [1:0]    xpos = 2'd0;
    logic [2:0]    ypos = 3'd0;
    logic          fld_adj = 1'b0;
    logic          vwin;
    logic          hstart;
    logic [IW-1:0] line_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    osd_window_pos #(
        .TICKS_PER_TENTH_US (TPT),
        .LINE_W             (10),
        .WIN_LINES          (WIN)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .vsync    (vsync),
        .std_625  (std_625),
        .xpos     (xpos),
        .ypos     (ypos),
        .fld_adj  (fld_adj),
        .vwin     (vwin),
        .hstart   (hstart),
        .line_idx (line_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check and report it if it failed.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected first line from the two tables, plus the adjust flag.
    function automatic int exp_first(input bit s625, input int y, input bit adj);
        int t625[8] = '{42, 44, 46, 48, 34, 36, 38, 40};
        int t525[8] = '{28, 30, 32, 34, 20, 22, 24, 26};
        return (s625 ? t625[y] : t525[y]) + (adj ? 1 : 0);
    endfunction

    // Pulse vsync with the given codes. New codes may be applied after the edge.
    task automatic sync_field(input bit s625, input int y, input int x, input bit adj,
                              input bit chg, input int y2, input int x2);
        @(negedge clk);
        std_625 = s625; ypos = 3'(y); xpos = 2'(x); fld_adj = adj;
        vsync = 1'b1;
        repeat (2) @(negedge clk);
        vsync = 1'b0;
        if (chg) begin
            ypos = 3'(y2); xpos = 2'(x2); fld_adj = ~adj; std_625 = ~s625;
        end
        repeat (10) @(negedge clk);
    endtask

    // Run one line and check the window, the index and the strobe position.
    task automatic do_line(input string req, input bit act, input int idx, input int dly);
        int seen = 0;
        int nst = 0;
        hsync = 1'b1;
        for (int k = 1; k <= LINE_CLKS; k++) begin
            @(negedge clk);
            if (k == 4) hsync = 1'b0;
            if (k == 2) begin
                check(req, "vwin", int'(vwin), int'(act));
                check(req, "line_idx", int'(line_idx), act ? idx : 0);
            end
            if (hstart) begin
                nst++;
                if (seen == 0) seen = k;
            end
        end
        check("R9", "hstart count", nst, act ? 1 : 0);
        if (act) check({req, " R1"}, "hstart delay", seen - 1, dly);
    endtask

    // Run a full field and compare each line with the expected window.
    task automatic run_field(input string req, input bit s625, input int y, input int x,
                             input bit adj, input int nlines, input bit chg,
                             input int y2, input int x2);
        int fl = exp_first(s625, y, adj);
        int dly = (172 - 10 * x) * TPT;
        sync_field(s625, y, x, adj, chg, y2, x2);
        for (int n = 1; n <= nlines; n++) begin
            bit a = (n >= fl) && (n < fl + WIN);
            do_line(req, a, n - fl, dly);
        end
    endtask

    // R10: outputs are quiet in reset and right after it.
    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R10", "vwin in reset", int'(vwin), 0);
        check("R10", "hstart in reset", int'(hstart), 0);
        check("R10", "line_idx in reset", int'(line_idx), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "vwin after reset", int'(vwin), 0);
    endtask

    // R2, R4, R6: 625-line code 3 with code-0 delay; the window runs its full length.
    task automatic t_625_full;
        run_field("R2 R4 R6", 1'b1, 3, 0, 1'b0, 75, 1'b0, 0, 0);
    endtask

    // R3: 525-line code 4 with the shortest delay.
    task automatic t_525_low;
        run_field("R3", 1'b0, 4, 3, 1'b0, 45, 1'b0, 0, 0);
    endtask

    // R2: 625-line code 4 with delay code 1.
    task automatic t_625_alt;
        run_field("R2", 1'b1, 4, 1, 1'b0, 60, 1'b0, 0, 0);
    endtask

    // R5: a short 525-line field cuts the window off early.
    task automatic t_field_end;
        run_field("R5", 1'b0, 3, 2, 1'b0, 40, 1'b0, 0, 0);
    endtask

    // R7: the adjust flag moves the first line down by one.
    task automatic t_adjust;
        run_field("R7", 1'b1, 0, 0, 1'b1, 70, 1'b0, 0, 0);
    endtask

    // R8: codes changed after the vertical edge do not affect the field.
    task automatic t_latch;
        run_field("R8", 1'b1, 1, 2, 1'b0, 70, 1'b1, 7, 0);
    endtask

    // R3: 525-line code 7 with delay code 2.
    task automatic t_525_top;
        run_field("R3", 1'b0, 7, 2, 1'b0, 50, 1'b0, 0, 0);
    endtask

    // Ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles >= WATCHDOG) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_625_full;
        t_525_low;
        t_625_alt;
        t_field_end;
        t_adjust;
        t_latch;
        t_525_top;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule